// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to 24 edge-triggered interrupt inputs to one vector output stream. Every piece of configuration sits behind a two-register window on a 32-bit memory-mapped slave: software first writes an internal register number into a select register, then reads or writes a data window that reaches whichever internal register is currently selected. The internal space holds an identification register, a read-only version register, an arbitration register and one 64-bit redirection entry per input, split into a low and a high 32-bit half.

When an unmasked input sees a rising edge, the block remembers it as pending. Pending inputs are handed out one at a time, lowest input number first, through a valid/ready handshake. Each handed-out item carries the 8-bit vector from the input's redirection entry and a 4-bit priority class, which is the vector's upper nibble.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Byte offset 0x00 is the select register. Writes store wdata[7:0]. Reads return the stored select value in bits 7..0 and zero in bits 31..8.
- R2: Byte offset 0x10 is the data window, reaching the internal register named by the select value. Reads through either offset return data on `rdata` one clock after the clock that samples `rd_en`. Any other byte offset reads zero and ignores writes.
- R3: Internal register 0x00 is the identification register. Bits 27..24 are writable and read back. All other bits read zero. It resets to zero.
- R4: Internal register 0x01 is the version register and always reads 0x0017_0011: the highest entry number 23 in bits 23..16 and version 0x11 in bits 7..0. Writes to it are ignored.
- R5: Internal register 0x02 is the arbitration register. It reads the identification field in bits 27..24 and zero elsewhere. Writes to it are ignored.
- R6: Entry n has its low half at internal register 0x10+2n and its high half at 0x10+2n+1. Both halves hold all 32 written bits. After reset every low half reads 0x0001_0000 and every high half reads zero.
- R7: Internal registers 0x03 to 0x0F and 0x40 to 0xFF read zero, and writes to them are ignored.
- R8: Bit 16 of an entry's low half is its mask. A rising edge on an input whose mask is 0 makes that input pending. A rising edge while the mask is 1 is dropped and is not delivered after a later unmask.
- R9: `vec_out` carries bits 7..0 of the delivered input's low half, and `vec_prio` equals `vec_out` divided by 16. While `vec_valid` is high and `vec_ready` is low, both hold steady.
- R10: When several inputs are pending, the lowest-numbered one is delivered first. With `vec_ready` held high, one item is delivered per clock.
- R11: If an input's edge is first sampled at clock k and the output stage is free, `vec_valid` is low after clock k and high after clock k+1.
- R12: After reset `vec_valid` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 24 | Interrupt inputs, edge-sensitive |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | The consumer accepts the offered vector |
| vec_out | output | 8 | Offered vector |
| vec_prio | output | 4 | Priority class of the offered vector |

## Verification
A wrong select decode or a misplaced half shows up on the very next window read as a value that differs from what software last wrote. The bench catches this against its own model of every internal register within one cycle of the read. A corrupted pending bit or mask shows up within two clocks of an edge: a vector that should appear is missing, a masked edge produces a vector, or the vectors arrive in the wrong order. Stalled-output corruption shows up as `vec_out` changing while `vec_ready` is low.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    parameter int N_IN      = 24;
    parameter int VEC_W     = 8;
    parameter int ADDR_W    = 5;
    parameter int MASK_BIT  = 16;
    parameter logic [7:0] VERSION = 8'h11;

    localparam int ENT_W          = $clog2(N_IN);
    localparam logic [7:0] ENT_BASE = 8'h10;
    localparam logic [7:0] ENT_END  = 8'(16 + 2 * N_IN);
    localparam logic [ADDR_W-1:0] SEL_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(N_IN - 1), 8'h00, VERSION};
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [N_IN-1:0]        masks,
    output logic [N_IN*VEC_W-1:0]  vectors
);
    typedef struct packed {
        logic [7:0]             sel;
        logic [3:0]             id;
        logic [N_IN-1:0][31:0]  lo;
        logic [N_IN-1:0][31:0]  hi;
        logic [31:0]            rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic  is_ent;
    logic [7:0] ent_off;
    logic [ENT_W-1:0] ent_num;
    logic [31:0] win_val;

    always_comb begin
        ent_off = s_q.sel - ENT_BASE;
        ent_num = ent_off[ENT_W:1];
        is_ent  = (s_q.sel >= ENT_BASE) && (s_q.sel < ENT_END);

        case (s_q.sel)
            8'h00:   win_val = {4'b0, s_q.id, 24'b0};
            8'h01:   win_val = VER_WORD;
            8'h02:   win_val = {4'b0, s_q.id, 24'b0};
            default: win_val = !is_ent ? 32'b0 :
                               (ent_off[0] ? s_q.hi[ent_num] : s_q.lo[ent_num]);
        endcase

        s_d = s_q;
        if (bus_wr) begin
            if (bus_addr == SEL_OFF) begin
                s_d.sel = bus_wdata[7:0];
            end else if (bus_addr == WIN_OFF) begin
                if (s_q.sel == 8'h00) begin
                    s_d.id = bus_wdata[27:24];
                end else if (is_ent) begin
                    if (ent_off[0]) s_d.hi[ent_num] = bus_wdata;
                    else            s_d.lo[ent_num] = bus_wdata;
                end
            end
        end
        if (bus_rd) begin
            if (bus_addr == SEL_OFF)      s_d.rdata = {24'b0, s_q.sel};
            else if (bus_addr == WIN_OFF) s_d.rdata = win_val;
            else                          s_d.rdata = 32'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < N_IN; i++) s_q.lo[i][MASK_BIT] <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;

    for (genvar g = 0; g < N_IN; g++) begin : g_out
        assign masks[g]                  = s_q.lo[g][MASK_BIT];
        assign vectors[g*VEC_W +: VEC_W] = s_q.lo[g][VEC_W-1:0];
    end

    // R4: version reads are constant
    assert_version_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == WIN_OFF && s_q.sel == 8'h01) |=> (bus_rdata == VER_WORD));

    // R2: offsets other than select and window read zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != WIN_OFF && bus_addr != SEL_OFF) |=> (bus_rdata == 32'b0));

    // R1: select readback has zero upper bits
    assert_sel_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_OFF) |=> (bus_rdata[31:8] == 24'b0));
endmodule

// File: rtl/irq_redir_deliver.sv
module irq_redir_deliver
    import irq_redir_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        irq_in,
    input  logic [N_IN-1:0]        masks,
    input  logic [N_IN*VEC_W-1:0]  vectors,
    input  logic                   vec_ready,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_out
);
    typedef struct packed {
        logic [N_IN-1:0]  prev;
        logic [N_IN-1:0]  pending;
        logic             valid;
        logic [VEC_W-1:0] vec;
    } dlv_t;

    dlv_t d_d, d_q;
    logic [N_IN-1:0]  rise, elig, clr;
    logic [ENT_W-1:0] pick;
    logic             found, slot_free;

    always_comb begin
        rise  = irq_in & ~d_q.prev & ~masks;
        elig  = d_q.pending & ~masks;
        pick  = '0;
        found = 1'b0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick  = ENT_W'(i);
                found = 1'b1;
            end
        end
        slot_free = !d_q.valid || vec_ready;
        clr = '0;
        d_d = d_q;
        d_d.prev = irq_in;
        if (slot_free) begin
            d_d.valid = found;
            if (found) begin
                d_d.vec   = vectors[int'(pick)*VEC_W +: VEC_W];
                clr[pick] = 1'b1;
            end
        end
        d_d.pending = (d_q.pending & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign vec_valid = d_q.valid;
    assign vec_out   = d_q.vec;

    // R9: offered vector holds while stalled
    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.valid && !vec_ready) |=> (d_q.valid && $stable(d_q.vec)));

    // R8: a masked, idle input never becomes pending
    assert_masked_no_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((d_q.pending & $past(masks & ~d_q.pending)) == '0));

    // R10: at most one pending bit retires per clock
    assert_one_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0($past(d_q.pending) & ~d_q.pending));
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [23:0]       irq_in,
    output logic              vec_valid,
    input  logic              vec_ready,
    output logic [7:0]        vec_out,
    output logic [3:0]        vec_prio
);
    logic [N_IN-1:0]       masks;
    logic [N_IN*VEC_W-1:0] vectors;

    irq_redir_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .masks     (masks),
        .vectors   (vectors)
    );

    irq_redir_deliver u_dlv (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .masks     (masks),
        .vectors   (vectors),
        .vec_ready (vec_ready),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    assign vec_prio = vec_out[VEC_W-1:VEC_W-4];
endmodule

// File: tb/irq_redir_ctrl_bench.sv
module irq_redir_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] irq_in = '0;
    logic        vec_valid, vec_ready = 1'b0;
    logic [7:0]  vec_out;
    logic [3:0]  vec_prio;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_lo [24];
    logic [31:0] m_hi [24];
    logic [3:0]  m_id;
    logic [7:0]  m_sel;

    always #4 clk = ~clk;

    irq_redir_ctrl u_irq_redir_ctrl (.*);

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(5'h00, {24'b0, idx});
        bus_write(5'h10, d);
        m_sel = idx;
        if (idx == 8'h00) m_id = d[27:24];
        else if (idx >= 8'h10 && idx < 8'h40) begin
            if (idx[0]) m_hi[(idx - 8'h10) >> 1] = d;
            else        m_lo[(idx - 8'h10) >> 1] = d;
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] idx);
        if (idx == 8'h00 || idx == 8'h02) return {4'b0, m_id, 24'b0};
        if (idx == 8'h01) return 32'h0017_0011;
        if (idx >= 8'h10 && idx < 8'h40)
            return idx[0] ? m_hi[(idx - 8'h10) >> 1] : m_lo[(idx - 8'h10) >> 1];
        return 32'b0;
    endfunction

    task automatic reg_check(input logic [7:0] idx, input string tag);
        logic [31:0] d;
        bus_write(5'h00, {24'b0, idx});
        bus_read(5'h10, d);
        check(d == exp_read(idx), tag, d, exp_read(idx));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 24; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = '0; end
        m_id = '0; m_sel = '0;
        repeat (3) @(negedge clk);
        // R12: reset outputs
        check(vec_valid == 1'b0, "R12 vec_valid after reset", {31'b0, vec_valid}, 0);
        check(bus_rdata == 32'b0, "R12 rdata after reset", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset values of entries
        reg_check(8'h10, "R6 entry0 low reset");
        reg_check(8'h3F, "R6 entry23 high reset");
        reg_check(8'h3E, "R6 entry23 low reset");
        // R4: version, and write ignored
        reg_check(8'h01, "R4 version");
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_check(8'h01, "R4 version after write");
        // R3, R5: id and arbitration
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_check(8'h00, "R3 id readback");
        reg_write(8'h02, 32'h0);
        reg_check(8'h02, "R5 arbitration mirrors id");
        // R1: select readback
        bus_write(5'h00, 32'hABCD_EF5A);
        bus_read(5'h00, d);
        check(d == 32'h0000_005A, "R1 select readback", d, 32'h5A);
        // R2: other offsets
        bus_write(5'h04, 32'h1234_5678);
        bus_read(5'h04, d);
        check(d == 32'h0, "R2 unmapped offset read", d, 0);
        bus_write(5'h00, 32'h0000_0000);
        bus_write(5'h08, 32'h0F00_0000);
        reg_check(8'h00, "R2 unmapped offset write ignored");
        // R7: unimplemented indices
        reg_write(8'h05, 32'hDEAD_BEEF);
        reg_check(8'h05, "R7 index 0x05 reads zero");
        reg_write(8'h40, 32'hDEAD_BEEF);
        reg_check(8'h40, "R7 index 0x40 reads zero");
        reg_check(8'h3F, "R7 write to 0x40 left entry23 alone");

        // Random register traffic (R6, R7, R3)
        for (int k = 0; k < 300; k++) begin
            logic [7:0] idx;
            idx = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(64, 255)) : 8'($urandom_range(0, 79));
            if ($urandom_range(0, 1) == 1) reg_write(idx, $urandom());
            else reg_check(idx, "R6 random window read");
        end

        // Mask every entry again before interrupt tests
        for (int i = 0; i < 24; i++) begin
            reg_write(8'(16 + 2 * i), 32'h0001_0000);
            reg_write(8'(17 + 2 * i), 32'h0);
        end
        reg_write(8'h16, 32'h0000_0035);   // entry 3
        reg_write(8'h1A, 32'h0000_0052);   // entry 5
        reg_write(8'h22, 32'h0000_009A);   // entry 9

        // R11, R10, R9: three simultaneous edges
        @(negedge clk);
        irq_in[3] = 1'b1; irq_in[5] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        check(vec_valid == 1'b0, "R11 not valid one clock after edge", {31'b0, vec_valid}, 0);
        @(negedge clk);
        check(vec_valid == 1'b1, "R11 valid two clocks after edge", {31'b0, vec_valid}, 1);
        check(vec_out == 8'h35, "R10 lowest input first", {24'b0, vec_out}, 32'h35);
        check(vec_prio == 4'h3, "R9 priority class", {28'b0, vec_prio}, 3);
        repeat (3) @(negedge clk);
        check(vec_valid && vec_out == 8'h35, "R9 held while stalled", {24'b0, vec_out}, 32'h35);
        vec_ready = 1'b1;
        @(negedge clk);
        check(vec_valid && vec_out == 8'h52, "R10 second item", {24'b0, vec_out}, 32'h52);
        check(vec_prio == 4'h5, "R9 priority class second", {28'b0, vec_prio}, 5);
        @(negedge clk);
        check(vec_valid && vec_out == 8'h9A, "R10 third item", {24'b0, vec_out}, 32'h9A);
        @(negedge clk);
        check(vec_valid == 1'b0, "R10 queue drained", {31'b0, vec_valid}, 0);
        irq_in = '0;

        // R8: masked edge dropped, not delivered after unmask
        @(negedge clk);
        irq_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        check(vec_valid == 1'b0, "R8 masked edge gives nothing", {31'b0, vec_valid}, 0);
        reg_write(8'h1E, 32'h0000_00C7);
        repeat (3) @(negedge clk);
        check(vec_valid == 1'b0, "R8 dropped edge not delivered after unmask", {31'b0, vec_valid}, 0);
        irq_in[7] = 1'b0;
        @(negedge clk);
        irq_in[7] = 1'b1;
        repeat (2) @(negedge clk);
        check(vec_valid && vec_out == 8'hC7, "R8 fresh edge after unmask", {24'b0, vec_out}, 32'hC7);
        check(vec_prio == 4'hC, "R9 priority class 0xC", {28'b0, vec_prio}, 32'hC);
        @(negedge clk);
        check(vec_valid == 1'b0, "R10 single item accepted", {31'b0, vec_valid}, 0);
        irq_in = '0;

        // Random edge bursts: expected order is ascending input number
        for (int t = 0; t < 20; t++) begin
            logic [23:0] burst;
            vec_ready = 1'b0;
            for (int i = 0; i < 24; i++) begin
                if ($urandom_range(0, 2) == 0) reg_write(8'(16 + 2 * i), {24'b0, 8'(i * 7 + t)});
                else                           reg_write(8'(16 + 2 * i), 32'h0001_0000 | 32'(i));
            end
            burst = 24'($urandom());
            @(negedge clk);
            irq_in = burst;
            repeat (3) @(negedge clk);
            vec_ready = 1'b1;
            for (int i = 0; i < 24; i++) begin
                if (burst[i] && !m_lo[i][16]) begin
                    check(vec_valid && vec_out == m_lo[i][7:0], "R10 random burst order",
                          {23'b0, vec_valid, vec_out}, {23'b0, 1'b1, m_lo[i][7:0]});
                    @(negedge clk);
                end
            end
            check(vec_valid == 1'b0, "R8 random burst no extra items", {31'b0, vec_valid}, 0);
            irq_in = '0;
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule